// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a synchronous static memory of 32-bit words split into four byte lanes, with flow-through reads and byte-granular writes. On each rising clock edge it decodes two address strobes (a processor strobe and a controller strobe), three chip selects, a global write enable, a byte write enable and four per-lane write inputs. From these it classifies the edge as a read start, a write start, a burst continuation (read or write), a deselect or an idle. A four-word burst sequencer supplies later addresses in linear or interleaved order.

Read data flows combinationally from the registered burst address to the output. An asynchronous output enable gates it. Instead of tristate pins, a `rvalid` flag reports whether the output drivers would be on. While `rvalid` is low, `rdata` reads as zero. Both interfaces are plain synchronous pins with no back-pressure. A host must present a command on every edge, and read data is valid in the cycle that follows the edge. Reset clears only the control state and leaves the array contents intact.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset `rvalid` is 0 and `rdata` is 0. Reset does not alter stored words.
- R2: A processor-strobe low edge with the device selected and `en0_n` low starts a read at `addr`. This holds whatever the write inputs and the controller strobe are. After that edge `rvalid` equals `!out_en_n` and `rdata` is the word at `addr`.
- R3: A controller-strobe low edge with the processor strobe high and the device selected starts a cycle at `addr`. If that edge carries a write command, the word at `addr` is written on the edge. Otherwise a read starts.
- R4: With `wr_all_n` low, a write updates all four lanes, whatever `wr_byte_n` and `lane_wr_n` are.
- R5: With `wr_all_n` high and `wr_byte_n` low, lane k (bits 8k+7..8k) is written only when `lane_wr_n[k]` is low. With both `wr_all_n` and `wr_byte_n` high, nothing is written and the edge is a read.
- R6: The byte write inputs are ignored on an edge that starts a read through the processor strobe.
- R7: After any edge that writes, `rvalid` is 0 regardless of `out_en_n`.
- R8: On a continuation edge with `adv_n` low, a write goes to the current burst address and the burst then advances. A read advances first and then shows the new address. `adv_n` is ignored on edges that start a cycle.
- R9: The burst keeps `addr` bits above bit 1 fixed and wraps within four words. When `seq_linear` is 1, the low two bits are base+count (mod 4). When it is 0, they are base XOR count.
- R10: The device is selected when `en0_n`=0, `en1`=1 and `en2_n`=0. A strobe edge that is not selected ends the burst, and `rvalid` stays 0 until the next start. `en0_n` high blocks the processor strobe (the edge is treated as if that strobe were high) but does not block the controller strobe.
- R11: `out_en_n` acts without a clock. In a read state `rvalid` follows `!out_en_n` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en0_n | input | 1 | Chip select 0, active low (gates processor strobe) |
| en1 | input | 1 | Chip select 1, active high |
| en2_n | input | 1 | Chip select 2, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_wr_n | input | 4 | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Output drivers on |

## Verification
On every cycle the assertions check four things. A selected processor-strobe edge yields `rvalid == !out_en_n` afterwards. A write edge or a deselecting strobe edge leaves the outputs off. Each continuation edge with advance low steps the burst count by one, and each start clears it. `rvalid` never rises while the output enable is high, and `rdata` is zero whenever `rvalid` is low. Only the bench's reference model can show the stored contents. That covers lane masking, writes ignored on processor-strobe edges, the linear and interleaved address orders, the blocking of the processor strobe by `en0_n`, and data surviving a reset.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DESEL,
    OP_START_RD,
    OP_START_WR,
    OP_CONT_RD,
    OP_CONT_WR
  } cyc_op_e;
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
  import sbs_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic          cpu_strb_n,
  input  logic          ctl_strb_n,
  input  logic          en0_n,
  input  logic          en1,
  input  logic          en2_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NL-1:0] lane_wr_n,
  input  logic          burst_act,
  output cyc_op_e       op,
  output logic [NL-1:0] lane_mask
);
  logic sel_ok;
  logic cpu_eff;
  logic wr_cmd;

  // en0_n gates only the processor strobe
  assign sel_ok  = !en0_n && en1 && !en2_n;
  assign cpu_eff = !cpu_strb_n && !en0_n;

  always_comb begin
    if (!wr_all_n)       lane_mask = '1;
    else if (!wr_byte_n) lane_mask = ~lane_wr_n;
    else                 lane_mask = '0;
  end

  assign wr_cmd = |lane_mask;

  always_comb begin
    if (cpu_eff)          op = sel_ok ? OP_START_RD : OP_DESEL;
    else if (!ctl_strb_n) op = !sel_ok ? OP_DESEL :
                               (wr_cmd ? OP_START_WR : OP_START_RD);
    else if (burst_act)   op = wr_cmd ? OP_CONT_WR : OP_CONT_RD;
    else                  op = OP_IDLE;
  end
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
  import sbs_pkg::*;
#(
  parameter int AW        = 8,
  parameter int BURST_LEN = 4,
  localparam int CW       = $clog2(BURST_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_op_e       op,
  input  logic          adv_n,
  input  logic          seq_linear,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] acc_addr,
  output logic [CW-1:0] burst_cnt,
  output logic          burst_act,
  output logic          rd_state
);
  logic [AW-1:0] base_q;
  logic [CW-1:0] low_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      burst_cnt <= '0;
      burst_act <= 1'b0;
      rd_state  <= 1'b0;
    end else begin
      unique case (op)
        OP_START_RD, OP_START_WR: begin
          base_q    <= addr;
          burst_cnt <= '0;
          burst_act <= 1'b1;
          rd_state  <= (op == OP_START_RD);
        end
        OP_DESEL: begin
          burst_act <= 1'b0;
          rd_state  <= 1'b0;
        end
        OP_CONT_RD, OP_CONT_WR: begin
          rd_state <= (op == OP_CONT_RD);
          if (!adv_n) burst_cnt <= burst_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  generate
    if (CW > 0) begin : g_seq
      assign low_bits = seq_linear ? base_q[CW-1:0] + burst_cnt
                                   : base_q[CW-1:0] ^ burst_cnt;
      assign acc_addr = {base_q[AW-1:CW], low_bits};
    end else begin : g_single
      assign low_bits = '0;
      assign acc_addr = base_q;
    end
  endgenerate
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array
  import sbs_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int NL    = LANES,
  parameter int LW    = LANE_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic [NL-1:0]  we_mask,
  input  logic [AW-1:0]  waddr,
  input  logic [NL*LW-1:0] wdata,
  input  logic [AW-1:0]  raddr,
  output logic [NL*LW-1:0] rdata
);
  genvar k;
  generate
    for (k = 0; k < NL; k++) begin : g_lane
      logic [LW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (we_mask[k]) mem[waddr] <= wdata[k*LW +: LW];
      end
      assign rdata[k*LW +: LW] = mem[raddr];
    end
  endgenerate
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int BURST_LEN = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              adv_n,
  input  logic              en0_n,
  input  logic              en1,
  input  logic              en2_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              out_en_n,
  input  logic              seq_linear,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  cyc_op_e           op;
  logic [LANES-1:0]  lane_mask;
  logic [LANES-1:0]  we_mask;
  logic [AW-1:0]     acc_addr;
  logic [AW-1:0]     wr_addr;
  logic [CW-1:0]     burst_cnt;
  logic              burst_act;
  logic              rd_state;
  logic [WORD_W-1:0] arr_q;

  sbs_cmd_decode #(.NL(LANES)) u_dec (
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
    .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
    .burst_act(burst_act), .op(op), .lane_mask(lane_mask)
  );

  sbs_burst_seq #(.AW(AW), .BURST_LEN(BURST_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .op(op), .adv_n(adv_n),
    .seq_linear(seq_linear), .addr(addr), .acc_addr(acc_addr),
    .burst_cnt(burst_cnt), .burst_act(burst_act), .rd_state(rd_state)
  );

  // start writes land at the strobed address, continuation writes at the burst pointer
  assign wr_addr = (op == OP_START_WR) ? addr : acc_addr;
  assign we_mask = (op == OP_START_WR || op == OP_CONT_WR) ? lane_mask : '0;

  sbs_lane_array #(.DEPTH(DEPTH), .NL(LANES), .LW(LANE_W)) u_arr (
    .clk(clk), .we_mask(we_mask), .waddr(wr_addr), .wdata(wdata),
    .raddr(acc_addr), .rdata(arr_q)
  );

  assign rvalid = burst_act && rd_state && !out_en_n;
  assign rdata  = rvalid ? arr_q : '0;
endmodule

module sync_burst_sram_chk
  import sbs_pkg::*;
#(
  parameter int CW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_strb_n,
  input logic              ctl_strb_n,
  input logic              adv_n,
  input logic              en0_n,
  input logic              en1,
  input logic              en2_n,
  input logic              wr_all_n,
  input logic              wr_byte_n,
  input logic [LANES-1:0]  lane_wr_n,
  input logic              out_en_n,
  input logic [WORD_W-1:0] rdata,
  input logic              rvalid,
  input cyc_op_e           op,
  input logic [CW-1:0]     burst_cnt
);
  logic sel_ok;
  assign sel_ok = !en0_n && en1 && !en2_n;

  assert_cpu_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strb_n && sel_ok) |=> (rvalid == !out_en_n));

  assert_write_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strb_n && (!wr_all_n || (!wr_byte_n && lane_wr_n != '1))) |=> !rvalid);

  assert_desel_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (((!cpu_strb_n && !en0_n) || !ctl_strb_n) && !sel_ok) |=> !rvalid);

  assert_burst_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_CONT_RD || op == OP_CONT_WR) && !adv_n)
      |=> (burst_cnt == CW'($past(burst_cnt) + 1'b1)));

  assert_start_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_START_RD || op == OP_START_WR) |=> (burst_cnt == '0));

  assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !out_en_n);

  assert_zero_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
  .adv_n(adv_n), .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
  .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
  .out_en_n(out_en_n), .rdata(rdata), .rvalid(rvalid),
  .op(op), .burst_cnt(burst_cnt)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_strb_n, ctl_strb_n, adv_n, en0_n, en1, en2_n;
  logic        wr_all_n, wr_byte_n, out_en_n, seq_linear;
  logic [3:0]  lane_wr_n;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic        rvalid;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sync_burst_sram #(.DEPTH(DEPTH)) u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
    .adv_n(adv_n), .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
    .out_en_n(out_en_n), .seq_linear(seq_linear), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  // behavioural reference model
  logic [31:0] ref_mem [DEPTH];
  bit          known   [DEPTH];
  bit          m_act, m_rd;
  int          m_base, m_cnt;

  function automatic int ptr();
    int lo;
    lo = seq_linear ? ((m_base + m_cnt) % 4) : ((m_base % 4) ^ m_cnt);
    return (m_base / 4) * 4 + lo;
  endfunction

  function automatic void mwrite(int a, logic [3:0] m);
    for (int k = 0; k < 4; k++)
      if (m[k]) ref_mem[a][k*8 +: 8] = wdata[k*8 +: 8];
    if (m == 4'hF) known[a] = 1'b1;
  endfunction

  always @(posedge clk) begin
    bit sel;
    logic [3:0] m;
    sel = !en0_n && en1 && !en2_n;
    m = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_wr_n : 4'h0);
    if (!rst_n) begin
      m_act = 0; m_rd = 0; m_base = 0; m_cnt = 0;
    end else if (!cpu_strb_n && !en0_n) begin
      if (sel) begin m_act = 1; m_rd = 1; m_base = addr; m_cnt = 0; end
      else begin m_act = 0; m_rd = 0; end
    end else if (!ctl_strb_n) begin
      if (sel) begin
        m_act = 1; m_base = addr; m_cnt = 0;
        if (m != 0) begin mwrite(addr, m); m_rd = 0; end
        else m_rd = 1;
      end else begin m_act = 0; m_rd = 0; end
    end else if (m_act) begin
      if (m != 0) begin
        mwrite(ptr(), m); m_rd = 0;
        if (!adv_n) m_cnt = (m_cnt + 1) % 4;
      end else begin
        if (!adv_n) m_cnt = (m_cnt + 1) % 4;
        m_rd = 1;
      end
    end
  end

  task automatic chk(input string tag);
    bit ev; logic [31:0] ed; int p;
    p  = ptr();
    ev = m_act && m_rd && !out_en_n;
    ed = ev ? ref_mem[p] : 32'h0;
    n_chk++;
    if (rvalid !== ev || (ev && known[p] && rdata !== ed) || (!ev && rdata !== 32'h0)) begin
      n_err++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk); #5; chk(tag);
  endtask

  task automatic idle();
    cpu_strb_n = 1; ctl_strb_n = 1; adv_n = 1;
    en0_n = 0; en1 = 1; en2_n = 0;
    wr_all_n = 1; wr_byte_n = 1; lane_wr_n = 4'hF; out_en_n = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    rst_n = 0; idle(); seq_linear = 1; addr = '0; wdata = '0;
    tick("R1");
    tick("R1");
    rst_n = 1;

    // fill words 0..15 through controller-strobe global writes
    for (int i = 0; i < 16; i++) begin
      idle(); ctl_strb_n = 0; wr_all_n = 0; wr_byte_n = 0; lane_wr_n = 4'h5;
      addr = AW'(i); wdata = 32'hA0000000 + i * 32'h01030507;
      tick("R4");
    end
    idle(); ctl_strb_n = 0; addr = 8'd2; tick("R3");

    // processor strobe with write noise: read, lanes untouched
    idle(); cpu_strb_n = 0; ctl_strb_n = 0; wr_all_n = 0; wr_byte_n = 0;
    lane_wr_n = 4'h0; addr = 8'd5; wdata = 32'hFFFFFFFF; adv_n = 0;
    tick("R2");
    idle(); tick("R6");

    // linear burst from 5: 5,6,7,4
    seq_linear = 1;
    idle(); cpu_strb_n = 0; addr = 8'd5; adv_n = 0; tick("R8");
    for (int i = 0; i < 4; i++) begin idle(); adv_n = 0; tick("R9"); end
    // interleaved burst from 5: 5,4,7,6
    seq_linear = 0;
    idle(); ctl_strb_n = 0; addr = 8'd5; tick("R9");
    for (int i = 0; i < 4; i++) begin idle(); adv_n = 0; tick("R9"); end
    seq_linear = 1;

    // byte writes in a burst
    idle(); cpu_strb_n = 0; addr = 8'd8; tick("R2");
    idle(); wr_byte_n = 0; lane_wr_n = 4'b1010; adv_n = 0; wdata = 32'h11223344;
    tick("R7");
    idle(); wr_all_n = 0; wdata = 32'h55667788; tick("R4");
    idle(); tick("R8");
    idle(); ctl_strb_n = 0; addr = 8'd8; tick("R5");
    idle(); lane_wr_n = 4'h0; tick("R5");
    if (rdata !== {8'hA8, 8'h22, 8'h28, 8'h44}) begin
      n_err++; $display("FAIL R5: word8=%h expected %h", rdata, {8'hA8, 8'h22, 8'h28, 8'h44});
    end
    n_chk++;
    idle(); out_en_n = 1; tick("R7");

    // asynchronous output enable
    idle(); out_en_n = 1; tick("R11");
    #3 out_en_n = 0; #1 chk("R11");
    #2 out_en_n = 1; #1 chk("R11");

    // chip selects
    idle(); cpu_strb_n = 0; addr = 8'd3; tick("R10");
    idle(); cpu_strb_n = 0; en0_n = 1; addr = 8'd10; tick("R10");
    idle(); ctl_strb_n = 0; en2_n = 1; addr = 8'd4; tick("R10");
    idle(); tick("R10");
    idle(); cpu_strb_n = 0; addr = 8'd6; tick("R10");
    idle(); cpu_strb_n = 0; en1 = 0; tick("R10");
    idle(); ctl_strb_n = 0; en0_n = 1; addr = 8'd4; tick("R10");

    // reset keeps the array
    idle(); rst_n = 0; tick("R1");
    rst_n = 1; idle(); ctl_strb_n = 0; addr = 8'd9; tick("R1");
    n_chk++;
    if (rdata !== 32'h55667788) begin
      n_err++; $display("FAIL R1: word9=%h expected %h", rdata, 32'h55667788);
    end
    idle(); tick("R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule